// File: doc/BRIEF.md
# Load-Dependent Frequency-Folding Oscillator

This block sets the switching cadence of a current-mode converter controller. It runs from a fixed system clock and reads a feedback level as an unsigned millivolt code from an external converter model. At heavy and nominal load the switching rate stays at a fixed 100 kHz. Below a light-load knee the rate falls in a straight line with the feedback level. Under deep light load it is pinned at a very low floor, which cuts switching losses in standby.

Every switching period begins with a single-clock start pulse. A maximum-duty window opens with that pulse and closes at 85 % of the period. A ramp phase count restarts at zero on each period, and downstream slope-compensation logic can use it. An optional pseudo-random dither moves each period's frequency by about ±6 % to spread the emission spectrum. The feedback code and the dither state are sampled only at a period start. The length they produce takes effect from the following period, so a running period is never cut short.

Top module: `fold_osc`

## Requirements
- R1: While reset is asserted, `pstart_o` and `duty_o` are low and `ramp_o` is 0. The first period after reset lasts SYS_HZ/FNOM_HZ clocks, which is 100 at the defaults.
- R2: With the feedback code at or above 1200 mV and dither off, the effective frequency is 100000 Hz.
- R3: For a code strictly between 800 and 1200 mV, the base frequency is 100000 − 240·(1200 − code) Hz, and it is never below 450 Hz.
- R4: With the code at or below 800 mV, the base frequency is 450 Hz. At defaults with dither off this gives a 22222-clock period.
- R5: A period lasts floor(SYS_HZ / f_eff) clocks, limited to the range 27..65535. f_eff is formed from `fb_mv_i` and `jit_en_i` as sampled in the clock where `pstart_o` is high, and it sets the length of the next period. Input changes at any other time have no effect.
- R6: `pstart_o` is high for exactly one clock at the first clock of every period.
- R7: `duty_o` is high for the first floor(85·L/100) clocks of each period of length L, starting in the `pstart_o` clock, and low for the rest of the period.
- R8: `ramp_o` is 0 in the `pstart_o` clock and rises by one each clock up to L−1.
- R9: Dither uses a 16-bit register seeded with 0xACE1. Its next value is {s[14:0], s[15]^s[13]^s[12]^s[10]}, taken once per period right after its value has been used. With offset j = s[6:0] − 64, f_eff = f + floor(f·j/1024) when `jit_en_i` is 1, and f_eff = f otherwise. The register stays nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fb_mv_i | input | 12 | Feedback level in millivolts, unsigned |
| jit_en_i | input | 1 | Enables frequency dither |
| pstart_o | output | 1 | One-clock pulse at each period start |
| duty_o | output | 1 | Maximum-duty window, high while switching is allowed |
| ramp_o | output | 16 | Phase count within the current period |

## Verification
The feedback code sampled in a period's start clock sets the length of the period that follows. That length shows up as the gap between the next start pulse and the one after it. The bench therefore keeps a one-period pipeline of expected lengths: the value computed at start pulse k is compared with the gap measured at pulse k+2. The duty count and the final ramp value are checked against the same expected length. The inputs are set to garbage for one clock early in each period and then given their planned value, so a change outside the sampling clock would show up as a wrong length.

// File: rtl/fold_osc_pkg.sv
package fold_osc_pkg;

  localparam int unsigned LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam int unsigned JIT_W     = 8;   // signed dither offset width
  localparam int unsigned JIT_SH    = 10;  // offset scale: f*j/1024

  typedef logic signed [JIT_W-1:0] jit_t;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/fold_osc_law.sv
module fold_osc_law
  import fold_osc_pkg::*;
#(
  parameter int unsigned FB_W        = 12,
  parameter int unsigned F_W         = 18,
  parameter int unsigned KNEE_MV     = 1200,
  parameter int unsigned FLOOR_MV    = 800,
  parameter int unsigned FNOM_HZ     = 100000,
  parameter int unsigned FMIN_HZ     = 450,
  parameter int unsigned SLOPE_HZ_MV = 240
) (
  input  logic [FB_W-1:0] fb_mv,
  input  jit_t            jit,
  input  logic            jit_en,
  output logic [F_W-1:0]  f_hz
);

  localparam int unsigned SPAN_HZ = FNOM_HZ - FMIN_HZ;
  localparam int unsigned EXT_W   = F_W + JIT_W + 1;

  logic [31:0]             drop;
  logic [F_W-1:0]          base;
  logic signed [EXT_W-1:0] base_s;
  logic signed [EXT_W-1:0] jit_s;
  logic signed [EXT_W-1:0] prod_s;
  logic signed [EXT_W-1:0] eff_s;

  // piecewise frequency-versus-feedback law
  always_comb begin
    drop = 32'(SLOPE_HZ_MV) * (32'(KNEE_MV) - 32'(fb_mv));
    if (32'(fb_mv) >= 32'(KNEE_MV)) begin
      base = F_W'(FNOM_HZ);
    end else if (32'(fb_mv) <= 32'(FLOOR_MV)) begin
      base = F_W'(FMIN_HZ);
    end else if (drop >= 32'(SPAN_HZ)) begin
      base = F_W'(FMIN_HZ);
    end else begin
      base = F_W'(32'(FNOM_HZ) - drop);
    end
  end

  // dither: f + floor(f * j / 2^JIT_SH)
  always_comb begin
    base_s = $signed({{(JIT_W+1){1'b0}}, base});
    jit_s  = $signed({{(F_W+1){jit[JIT_W-1]}}, jit});
    prod_s = base_s * jit_s;
    eff_s  = jit_en ? (base_s + (prod_s >>> JIT_SH)) : base_s;
    f_hz   = F_W'(eff_s);
  end

endmodule

// File: rtl/fold_osc_dither.sv
module fold_osc_dither
  import fold_osc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output jit_t jit
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step) begin
      lfsr_d = lfsr_step(lfsr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  assign jit = $signed({1'b0, lfsr_q[6:0]}) - 8'sd64;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R9

endmodule

// File: rtl/fold_osc_div.sv
module fold_osc_div #(
  parameter int unsigned DVD   = 10_000_000,
  parameter int unsigned DVD_W = 24,
  parameter int unsigned DSR_W = 18,
  parameter int unsigned Q_W   = 16,
  parameter int unsigned MIN_Q = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DSR_W-1:0] dsr_i,
  output logic             busy,
  output logic [Q_W-1:0]   q_o
);

  localparam int unsigned      STEP_W = $clog2(DVD_W + 1);
  localparam logic [DVD_W-1:0] DVD_C  = DVD_W'(DVD);

  logic [DSR_W-1:0]  rem_q, rem_d;
  logic [DVD_W-1:0]  dvd_q, dvd_d;
  logic [DVD_W-1:0]  quo_q, quo_d;
  logic [DSR_W-1:0]  dsr_q, dsr_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              busy_q, busy_d;
  logic [Q_W-1:0]    q_q, q_d;
  logic [DSR_W:0]    trial;
  logic              ge;
  logic [Q_W-1:0]    q_sat;

  // one restoring step per clock
  always_comb begin
    trial = {rem_q, dvd_q[DVD_W-1]};
    ge    = trial >= {1'b0, dsr_q};
  end

  generate
    if (DVD_W > Q_W) begin : g_sat
      always_comb begin
        if (quo_d > DVD_W'((2 ** Q_W) - 1)) begin
          q_sat = '1;
        end else if (quo_d < DVD_W'(MIN_Q)) begin
          q_sat = Q_W'(MIN_Q);
        end else begin
          q_sat = Q_W'(quo_d);
        end
      end
    end else begin : g_wide
      always_comb begin
        if (Q_W'(quo_d) < Q_W'(MIN_Q)) begin
          q_sat = Q_W'(MIN_Q);
        end else begin
          q_sat = Q_W'(quo_d);
        end
      end
    end
  endgenerate

  always_comb begin
    rem_d  = rem_q;
    dvd_d  = dvd_q;
    quo_d  = quo_q;
    dsr_d  = dsr_q;
    step_d = step_q;
    busy_d = busy_q;
    q_d    = q_q;
    if (start) begin
      rem_d  = '0;
      dvd_d  = DVD_C;
      quo_d  = '0;
      dsr_d  = dsr_i;
      step_d = STEP_W'(DVD_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d  = ge ? DSR_W'(trial - {1'b0, dsr_q}) : DSR_W'(trial);
      dvd_d  = {dvd_q[DVD_W-2:0], 1'b0};
      quo_d  = {quo_q[DVD_W-2:0], ge};
      step_d = step_q - STEP_W'(1);
      if (step_q == STEP_W'(1)) begin
        busy_d = 1'b0;
        q_d    = q_sat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      q_q    <= Q_W'(MIN_Q);
    end else begin
      rem_q  <= rem_d;
      dvd_q  <= dvd_d;
      quo_q  <= quo_d;
      dsr_q  <= dsr_d;
      step_q <= step_d;
      busy_q <= busy_d;
      q_q    <= q_d;
    end
  end

  assign busy = busy_q;
  assign q_o  = q_q;

  AST_DIV_IDLE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R5
  AST_DIV_NONZERO_DSR: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (dsr_i != '0)); // R3

endmodule

// File: rtl/fold_osc.sv
module fold_osc
  import fold_osc_pkg::*;
#(
  parameter int unsigned SYS_HZ      = 10_000_000,
  parameter int unsigned FB_W        = 12,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned KNEE_MV     = 1200,
  parameter int unsigned FLOOR_MV    = 800,
  parameter int unsigned FNOM_HZ     = 100000,
  parameter int unsigned FMIN_HZ     = 450,
  parameter int unsigned SLOPE_HZ_MV = 240,
  parameter int unsigned DUTY_PCT    = 85
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_W-1:0]  fb_mv_i,
  input  logic             jit_en_i,
  output logic             pstart_o,
  output logic             duty_o,
  output logic [LEN_W-1:0] ramp_o
);

  localparam int unsigned F_W      = $clog2(FNOM_HZ * 2);
  localparam int unsigned DVD_W    = $clog2(SYS_HZ + 1);
  localparam int unsigned MIN_LEN  = DVD_W + 3;
  localparam int unsigned NOM_LEN  = SYS_HZ / FNOM_HZ;
  localparam int unsigned NOM_DUTY = (NOM_LEN * DUTY_PCT) / 100;
  localparam int unsigned PROD_W   = LEN_W + 7;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  logic             running_q, running_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] duty_q, duty_d;
  logic             wrap;
  logic             pstart;
  logic             cnt_en;
  jit_t             jit;
  logic [F_W-1:0]   f_eff;
  logic             div_busy;
  logic [LEN_W-1:0] div_q;
  logic [LEN_W-1:0] div_duty;

  fold_osc_dither u_dither (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (pstart),
    .jit   (jit)
  );

  fold_osc_law #(
    .FB_W        (FB_W),
    .F_W         (F_W),
    .KNEE_MV     (KNEE_MV),
    .FLOOR_MV    (FLOOR_MV),
    .FNOM_HZ     (FNOM_HZ),
    .FMIN_HZ     (FMIN_HZ),
    .SLOPE_HZ_MV (SLOPE_HZ_MV)
  ) u_law (
    .fb_mv  (fb_mv_i),
    .jit    (jit),
    .jit_en (jit_en_i),
    .f_hz   (f_eff)
  );

  fold_osc_div #(
    .DVD   (SYS_HZ),
    .DVD_W (DVD_W),
    .DSR_W (F_W),
    .Q_W   (LEN_W),
    .MIN_Q (MIN_LEN)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (pstart),
    .dsr_i (f_eff),
    .busy  (div_busy),
    .q_o   (div_q)
  );

  always_comb begin
    cnt_en   = running_q;
    pstart   = running_q && (cnt_q == '0);
    wrap     = running_q && (cnt_q == len_q - LEN_W'(1));
    div_duty = LEN_W'(({7'd0, div_q} * PROD_W'(DUTY_PCT)) / PROD_W'(100));
  end

  // period counter next state
  always_comb begin
    running_d = 1'b1;
    cnt_d     = cnt_q;
    len_d     = len_q;
    duty_d    = duty_q;
    if (cnt_en) begin
      if (wrap) begin
        cnt_d  = '0;
        len_d  = div_q;
        duty_d = div_duty;
      end else begin
        cnt_d  = cnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      len_q     <= LEN_W'(NOM_LEN);
      duty_q    <= LEN_W'(NOM_DUTY);
    end else begin
      running_q <= running_d;
      cnt_q     <= cnt_d;
      len_q     <= len_d;
      duty_q    <= duty_d;
    end
  end

  assign pstart_o = pstart;
  assign duty_o   = running_q && (cnt_q < duty_q);
  assign ramp_o   = cnt_q;

  AST_PSTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    pstart_o |=> !pstart_o); // R6
  AST_DUTY_OPENS: assert property (@(posedge clk) disable iff (!rst_int_n)
    pstart_o |-> duty_o); // R7
  AST_DUTY_CLOSED_AT_END: assert property (@(posedge clk) disable iff (!rst_int_n)
    wrap |-> !duty_o); // R7
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (running_q && !wrap) |=> $stable(len_q)); // R5
  AST_DIV_READY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    wrap |-> !div_busy); // R5
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (running_q && !wrap) |=> (ramp_o == $past(ramp_o) + LEN_W'(1))); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!pstart_o && !duty_o)); // R1

endmodule

// File: tb/fold_osc_tb_top.sv
module fold_osc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NOM_LEN    = 100;
  localparam int MIN_LEN    = 27;
  localparam int N_DIR      = 10;
  localparam int N_PER      = 50;
  localparam int WDOG       = 190000;

  logic        clk;
  logic        rst_n;
  logic [11:0] fb_mv_i;
  logic        jit_en_i;
  logic        pstart_o;
  logic        duty_o;
  logic [15:0] ramp_o;

  int checks;
  int fails;

  fold_osc dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_mv_i  (fb_mv_i),
    .jit_en_i (jit_en_i),
    .pstart_o (pstart_o),
    .duty_o   (duty_o),
    .ramp_o   (ramp_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // expected period length from the requirements (R2, R3, R4, R5, R9)
  function automatic int exp_len(input int fb, input bit en, input logic [15:0] s);
    longint f, j, fe, q;
    if (fb >= 1200)     f = 100000;
    else if (fb <= 800) f = 450;
    else                f = 100000 - 240 * (1200 - fb);
    if (f < 450) f = 450;
    j  = longint'(s[6:0]) - 64;
    fe = en ? f + ((f * j) >>> 10) : f;
    q  = 10000000 / fe;
    if (q < MIN_LEN) q = MIN_LEN;
    if (q > 65535)   q = 65535;
    return int'(q);
  endfunction

  function automatic string tag_of(input int fb, input bit en);
    if (en)         return "R9";
    if (fb >= 1200) return "R2";
    if (fb <= 800)  return "R4";
    return "R3";
  endfunction

  task automatic pick_stim(input int k, output int fb, output bit en);
    case (k)
      1:  begin fb = 2000; en = 1'b0; end
      2:  begin fb = 1200; en = 1'b0; end
      3:  begin fb = 1199; en = 1'b0; end
      4:  begin fb = 1000; en = 1'b0; end
      5:  begin fb = 801;  en = 1'b0; end
      6:  begin fb = 800;  en = 1'b0; end
      7:  begin fb = 4095; en = 1'b1; end
      8:  begin fb = 0;    en = 1'b1; end
      9:  begin fb = 1100; en = 1'b1; end
      10: begin fb = 1500; en = 1'b1; end
      default: begin
        fb = 850 + int'($urandom % 3246);
        en = 1'b1 & $urandom;
      end
    endcase
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R5 watchdog actual=hung expected=%0d periods", N_PER);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int          k;
    int          meas;
    int          dcnt;
    int          cur_exp;
    int          nxt_exp;
    string       cur_tag;
    string       nxt_tag;
    logic [15:0] lm;
    int          chg;
    bit          prev_ps;
    int          last_ramp;
    int          fb_drv;
    bit          en_drv;

    checks = 0;
    fails  = 0;
    void'($urandom(32'd20240611));
    k = 0; meas = 0; dcnt = 0; cur_exp = 0;
    nxt_exp = NOM_LEN; nxt_tag = "R1"; cur_tag = "R1";
    lm = 16'hACE1; chg = 0; prev_ps = 1'b0; last_ramp = 0;
    fb_drv = 3000; en_drv = 1'b0;
    fb_mv_i  = 12'(fb_drv);
    jit_en_i = en_drv;
    rst_n    = 1'b0;

    repeat (5) @(negedge clk);
    check(pstart_o == 1'b0, "R1 pstart in reset", longint'(pstart_o), 0);
    check(duty_o == 1'b0, "R1 duty in reset", longint'(duty_o), 0);
    check(ramp_o == 16'd0, "R1 ramp in reset", longint'(ramp_o), 0);
    rst_n = 1'b1;

    while (k <= N_PER) begin
      @(negedge clk);
      if (pstart_o) begin
        check(!prev_ps, "R6 pulse width", longint'(prev_ps), 0);
        check(ramp_o == 16'd0, "R8 ramp at start", longint'(ramp_o), 0);
        if (k > 0) begin
          check(meas == cur_exp, {cur_tag, " R5 period length"}, meas, cur_exp);
          check(dcnt == (cur_exp * 85) / 100, "R7 duty clocks", dcnt, (cur_exp * 85) / 100);
          check(last_ramp == cur_exp - 1, "R8 final ramp", last_ramp, cur_exp - 1);
        end
        cur_exp = nxt_exp;
        cur_tag = nxt_tag;
        nxt_exp = exp_len(fb_drv, en_drv, lm);
        nxt_tag = tag_of(fb_drv, en_drv);
        lm      = lfsr_nx(lm);
        k++;
        meas = 0;
        dcnt = 0;
        chg  = 1;
      end else if (chg == 1) begin
        // garbage outside the sampling clock must not matter (R5)
        fb_mv_i  = 12'($urandom);
        jit_en_i = 1'b1 & $urandom;
        chg = 2;
      end else if (chg == 2) begin
        pick_stim(k, fb_drv, en_drv);
        fb_mv_i  = 12'(fb_drv);
        jit_en_i = en_drv;
        chg = 0;
      end
      meas++;
      if (duty_o) dcnt++;
      last_ramp = int'(ramp_o);
      prev_ps   = pstart_o;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule